// File: doc/BRIEF.md
# Paged 16-to-32-bit Register Access Bridge

This block connects a decoded MDIO clause-22 management port to an on-chip register bus whose registers are 32 bits wide. The management side arrives already deserialised: one request carries a PHY address, a register number, a direction flag and 16 bits of write data. The bridge recognises one PHY address and answers with 16-bit read data and a one-cycle valid strobe. The internal side is a single request/acknowledge port carrying a word address, a write enable and 32-bit data in each direction.

Since a PHY register holds only 16 bits, each 32-bit internal word is reached in two steps. A page register supplies the upper word-address bits. Sixteen window registers choose the word inside the page and carry its lower half. One shared register carries the upper half. Software first sets the page. To write, it sends the low half to a window and then the high half to the shared register, and only that second write goes out on the bus. To read, it reads a window, which starts the bus read and returns the low half. A later read of the shared register returns the high half of that same bus read.

A single bus access is outstanding at any time. While it waits for the acknowledge, the bridge raises a busy flag and takes no new management request. A requester that keeps its request asserted is served as soon as the flag drops.

Top module: `mdio_page_bridge`

## Requirements
- R1: A request whose PHY address differs from 0x1F starts no bus access and produces no read strobe. It leaves the page, the latched low half, the latched window index and the held high half unchanged.
- R2: A write to register 0x1F loads write-data bits [9:0] into the page, and the upper write-data bits are dropped. A read of register 0x1F returns the page zero-extended to 16 bits, with the read strobe one cycle after acceptance.
- R3: A write to a window register 0x00–0x0F stores the 16-bit data as the pending low half and stores bits [3:0] of the register number as the pending window index. It starts no bus access.
- R4: A write to register 0x10 starts exactly one bus write. The word address is {page, pending window index}, so page bits sit at byte-address bits [15:6] and window bits at [5:2]. The data is {write data, pending low half}.
- R5: A read of window n starts one bus read at word address {page, n}. In the cycle after the acknowledge, read data bits [15:0] appear on the management read data together with the read strobe.
- R6: A read of register 0x10 starts no bus access. One cycle after acceptance it returns bits [31:16] of the data from the most recent window read.
- R7: From the cycle after an access is accepted up to and including its acknowledge cycle, busy is high and the bus request stays asserted. A request held during that time is accepted in the first cycle after the acknowledge.
- R8: While the bus request waits for its acknowledge, address, write enable and write data hold steady.
- R9: Reset clears page, pending low half, pending window index and held high half. Just after reset, a read of 0x10 returns 0, and a write of 0x10 writes {data, 0x0000} to word address 0.
- R10: A read of any other register of PHY 0x1F (0x11–0x1E) returns 0 with the read strobe one cycle after acceptance, and it starts no bus access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| md_req | input | 1 | Management request; taken on a clock edge where md_busy is low |
| md_wr | input | 1 | 1 = write, 0 = read |
| md_phy | input | 5 | PHY address of the request |
| md_reg | input | 5 | Register number of the request |
| md_wdata | input | 16 | Write data |
| md_busy | output | 1 | High while a bus access is outstanding; requests are held off |
| md_rdata | output | 16 | Read data, valid with md_rvalid |
| md_rvalid | output | 1 | One-cycle strobe for read data |
| bus_req | output | 1 | Internal access request, held until bus_ack |
| bus_we | output | 1 | Internal access is a write |
| bus_addr | output | 14 | Internal word address (byte address bits [15:2]) |
| bus_wdata | output | 32 | Internal write data |
| bus_ack | input | 1 | Internal access completes on the edge where this is high |
| bus_rdata | input | 32 | Internal read data, sampled with bus_ack |

## Verification
A write of the high half straight after reset, with no window write before it, must land at word 0 with a zero low half. A bridge that left its latches undefined, or that sent the bus write on the window write, would show a wrong address or a second bus transaction. Foreign-PHY writes aimed at the page, at a window and at the high register are each followed by own-PHY reads and a committed write. A decoder that ignored the PHY address would show a changed page, low half or window index there. A read of the high half is held against the bus until the window read completes, with acknowledge latencies from zero to several cycles. A bridge that accepted it early would return the stale high half, and one that counted the busy window wrong would show busy for a different number of cycles than the latency plus one.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

    // class of a management register access after decode
    typedef enum logic [2:0] {
        KIND_MISS,   // another PHY address
        KIND_WIN,    // low-half window
        KIND_HIGH,   // shared high half
        KIND_PAGE,   // page select
        KIND_OTHER   // unused register of this PHY
    } reg_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } bridge_st_e;

endpackage

// File: rtl/mdio_reg_decode.sv
module mdio_reg_decode
    import mdio_bridge_pkg::*;
#(
    parameter logic [4:0] OWN_PHY  = 5'h1F,
    parameter logic [4:0] PAGE_REG = 5'h1F,
    parameter logic [4:0] HIGH_REG = 5'h10,
    parameter int         WIN_W    = 4
) (
    input  logic [4:0]       phy,
    input  logic [4:0]       regnum,
    output reg_kind_e        kind,
    output logic [WIN_W-1:0] win
);
    localparam logic [5:0] NUM_WIN = 6'(1 << WIN_W);

    always_comb begin
        win = regnum[WIN_W-1:0];
        if (phy != OWN_PHY) begin
            kind = KIND_MISS;
        end else if ({1'b0, regnum} < NUM_WIN) begin
            kind = KIND_WIN;
        end else if (regnum == HIGH_REG) begin
            kind = KIND_HIGH;
        end else if (regnum == PAGE_REG) begin
            kind = KIND_PAGE;
        end else begin
            kind = KIND_OTHER;
        end
    end
endmodule

// File: rtl/mdio_word_addr.sv
module mdio_word_addr #(
    parameter int PAGE_W = 10,
    parameter int WIN_W  = 4,
    localparam int ADDR_W = PAGE_W + WIN_W
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [WIN_W-1:0]  win,
    output logic [ADDR_W-1:0] addr
);
    // page forms the upper word-address bits, window index the lower ones
    always_comb addr = {page, win};
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
    import mdio_bridge_pkg::*;
#(
    parameter logic [4:0] OWN_PHY  = 5'h1F,
    parameter logic [4:0] PAGE_REG = 5'h1F,
    parameter logic [4:0] HIGH_REG = 5'h10,
    parameter int         PAGE_W   = 10,
    parameter int         WIN_W    = 4,
    parameter int         HALF_W   = 16,
    localparam int ADDR_W = PAGE_W + WIN_W,
    localparam int DATA_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              md_req,
    input  logic              md_wr,
    input  logic [4:0]        md_phy,
    input  logic [4:0]        md_reg,
    input  logic [HALF_W-1:0] md_wdata,
    output logic              md_busy,
    output logic [HALF_W-1:0] md_rdata,
    output logic              md_rvalid,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);
    typedef struct packed {
        bridge_st_e        st;
        logic [PAGE_W-1:0] page;
        logic [HALF_W-1:0] lo;
        logic [WIN_W-1:0]  win;
        logic [HALF_W-1:0] hi;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [HALF_W-1:0] rdata;
        logic              rvalid;
    } bridge_s;

    bridge_s state_d, state_q;

    reg_kind_e         kind;
    logic [WIN_W-1:0]  dec_win;
    logic [WIN_W-1:0]  win_sel;
    logic [ADDR_W-1:0] word_addr;

    mdio_reg_decode #(
        .OWN_PHY  (OWN_PHY),
        .PAGE_REG (PAGE_REG),
        .HIGH_REG (HIGH_REG),
        .WIN_W    (WIN_W)
    ) u_decode (
        .phy    (md_phy),
        .regnum (md_reg),
        .kind   (kind),
        .win    (dec_win)
    );

    // a window read addresses the requested window, a high write the latched one
    always_comb win_sel = (kind == KIND_WIN) ? dec_win : state_q.win;

    mdio_word_addr #(
        .PAGE_W (PAGE_W),
        .WIN_W  (WIN_W)
    ) u_addr (
        .page (state_q.page),
        .win  (win_sel),
        .addr (word_addr)
    );

    always_comb begin
        state_d        = state_q;
        state_d.rvalid = 1'b0;
        if (state_q.st == ST_WAIT) begin
            if (bus_ack) begin
                state_d.st = ST_IDLE;
                if (!state_q.we) begin
                    state_d.rdata  = bus_rdata[HALF_W-1:0];
                    state_d.hi     = bus_rdata[DATA_W-1:HALF_W];
                    state_d.rvalid = 1'b1;
                end
            end
        end else if (md_req) begin
            unique case (kind)
                KIND_PAGE: begin
                    if (md_wr) begin
                        state_d.page = md_wdata[PAGE_W-1:0];
                    end else begin
                        state_d.rdata  = HALF_W'(state_q.page);
                        state_d.rvalid = 1'b1;
                    end
                end
                KIND_WIN: begin
                    if (md_wr) begin
                        state_d.lo  = md_wdata;
                        state_d.win = dec_win;
                    end else begin
                        state_d.addr = word_addr;
                        state_d.we   = 1'b0;
                        state_d.st   = ST_WAIT;
                    end
                end
                KIND_HIGH: begin
                    if (md_wr) begin
                        state_d.addr  = word_addr;
                        state_d.wdata = {md_wdata, state_q.lo};
                        state_d.we    = 1'b1;
                        state_d.st    = ST_WAIT;
                    end else begin
                        state_d.rdata  = state_q.hi;
                        state_d.rvalid = 1'b1;
                    end
                end
                KIND_OTHER: begin
                    if (!md_wr) begin
                        state_d.rdata  = '0;
                        state_d.rvalid = 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{st: ST_IDLE, default: '0};
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        md_busy   = (state_q.st == ST_WAIT);
        bus_req   = (state_q.st == ST_WAIT);
        bus_we    = state_q.we;
        bus_addr  = state_q.addr;
        bus_wdata = state_q.wdata;
        md_rdata  = state_q.rdata;
        md_rvalid = state_q.rvalid;
    end
endmodule

// File: rtl/mdio_page_bridge_chk.sv
module mdio_page_bridge_chk #(
    parameter logic [4:0] OWN_PHY  = 5'h1F,
    parameter logic [4:0] HIGH_REG = 5'h10,
    parameter int         WIN_W    = 4,
    parameter int         ADDR_W   = 14,
    parameter int         HALF_W   = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                md_req,
    input logic                md_wr,
    input logic [4:0]          md_phy,
    input logic [4:0]          md_reg,
    input logic [HALF_W-1:0]   md_wdata,
    input logic                md_busy,
    input logic [HALF_W-1:0]   md_rdata,
    input logic                md_rvalid,
    input logic                bus_req,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [2*HALF_W-1:0] bus_wdata,
    input logic                bus_ack,
    input logic [2*HALF_W-1:0] bus_rdata
);
    localparam logic [5:0] NUM_WIN = 6'(1 << WIN_W);

    logic take, own, is_win;
    always_comb begin
        take   = md_req && !md_busy;
        own    = (md_phy == OWN_PHY);
        is_win = ({1'b0, md_reg} < NUM_WIN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R9: assert (!bus_req && !md_busy && !md_rvalid);
        end
    end

    assert_foreign_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !own) |=> (!bus_req && !md_rvalid));

    assert_win_write_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && own && md_wr && is_win) |=> !bus_req);

    assert_high_write_issues_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && own && md_wr && md_reg == HIGH_REG)
        |=> (bus_req && bus_we && bus_wdata[2*HALF_W-1:HALF_W] == $past(md_wdata)));

    assert_win_read_issues_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && own && !md_wr && is_win) |=> (bus_req && !bus_we));

    assert_read_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && !bus_we)
        |=> (md_rvalid && md_rdata == $past(bus_rdata[HALF_W-1:0])));

    assert_high_read_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && own && !md_wr && md_reg == HIGH_REG) |=> (!bus_req && md_rvalid));

    assert_req_drops_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> (!bus_req && !md_busy));

    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack)
        |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));
endmodule

bind mdio_page_bridge mdio_page_bridge_chk #(
    .OWN_PHY  (OWN_PHY),
    .HIGH_REG (HIGH_REG),
    .WIN_W    (WIN_W),
    .ADDR_W   (ADDR_W),
    .HALF_W   (HALF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .md_req    (md_req),
    .md_wr     (md_wr),
    .md_phy    (md_phy),
    .md_reg    (md_reg),
    .md_wdata  (md_wdata),
    .md_busy   (md_busy),
    .md_rdata  (md_rdata),
    .md_rvalid (md_rvalid),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata)
);

// File: tb/tb_mdio_page_bridge.sv
`timescale 1ns/1ps
module tb_mdio_page_bridge;
    localparam logic [4:0] PHY = 5'h1F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        md_req = 1'b0, md_wr = 1'b0;
    logic [4:0]  md_phy = '0, md_reg = '0;
    logic [15:0] md_wdata = '0;
    logic        md_busy, md_rvalid;
    logic [15:0] md_rdata;
    logic        bus_req, bus_we;
    logic [13:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #2 clk = ~clk;

    mdio_page_bridge dut (
        .clk(clk), .rst_n(rst_n),
        .md_req(md_req), .md_wr(md_wr), .md_phy(md_phy), .md_reg(md_reg),
        .md_wdata(md_wdata), .md_busy(md_busy), .md_rdata(md_rdata),
        .md_rvalid(md_rvalid), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural bus memory and responder ----------------
    logic [31:0] mem [int];
    int          lat = 0;
    int          wcnt = 0;
    logic [13:0] log_addr [$];
    logic        log_we   [$];
    logic [31:0] log_data [$];

    function automatic logic [31:0] mem_rd(input logic [13:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return {2'b10, a, 2'b01, ~a};
    endfunction

    always @(negedge clk) begin
        bus_ack = 1'b0;
        if (rst_n && bus_req) begin
            if (wcnt >= lat) begin
                bus_ack = 1'b1;
                wcnt = 0;
                log_addr.push_back(bus_addr);
                log_we.push_back(bus_we);
                log_data.push_back(bus_we ? bus_wdata : mem_rd(bus_addr));
                if (bus_we) mem[int'(bus_addr)] = bus_wdata;
                else bus_rdata = mem_rd(bus_addr);
            end else begin
                wcnt++;
            end
        end
    end

    // ---------------- per-cycle busy model ----------------
    bit mdl_busy = 0;
    always @(negedge clk) begin
        #1;
        if (!rst_n) begin
            mdl_busy = 0;
        end else begin
            chk(md_busy == mdl_busy, "R7 busy", 32'(md_busy), 32'(mdl_busy));
            chk(bus_req == mdl_busy, "R7 bus_req", 32'(bus_req), 32'(mdl_busy));
            if (mdl_busy) mdl_busy = !bus_ack;
            else mdl_busy = md_req && md_phy == PHY &&
                            ((md_wr && md_reg == 5'h10) || (!md_wr && md_reg < 5'h10));
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- reference state ----------------
    logic [9:0]  m_page = '0;
    logic [15:0] m_lo = '0, m_hi = '0;
    logic [3:0]  m_win = '0;

    task automatic md_access(input logic [4:0] phy, input logic [4:0] rg, input bit wr,
                             input logic [15:0] wd, output logic [15:0] rd, output bit got);
        @(negedge clk);
        md_phy = phy; md_reg = rg; md_wr = wr; md_wdata = wd; md_req = 1'b1;
        while (md_busy) @(negedge clk);
        @(negedge clk);
        md_req = 1'b0;
        got = 0; rd = '0;
        if (!wr) begin
            for (int i = 0; i < 30 && !got; i++) begin
                if (md_rvalid) begin got = 1; rd = md_rdata; end
                else @(negedge clk);
            end
        end
    endtask

    task automatic settle();
        while (md_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_no_bus(input string tag);
        settle();
        chk(log_addr.size() == 0, tag, 32'(log_addr.size()), 0);
        log_addr.delete(); log_we.delete(); log_data.delete();
    endtask

    task automatic expect_bus(input string tag, input logic [13:0] a, input bit we,
                              input logic [31:0] d);
        settle();
        chk(log_addr.size() == 1, {tag, " count"}, 32'(log_addr.size()), 1);
        if (log_addr.size() > 0) begin
            chk(log_addr[0] == a, {tag, " addr"}, 32'(log_addr[0]), 32'(a));
            chk(log_we[0] == we, {tag, " we"}, 32'(log_we[0]), 32'(we));
            chk(log_data[0] == d, {tag, " data"}, log_data[0], d);
        end
        log_addr.delete(); log_we.delete(); log_data.delete();
    endtask

    task automatic wr_page(input logic [15:0] v);
        logic [15:0] rd; bit got;
        md_access(PHY, 5'h1F, 1, v, rd, got);
        m_page = v[9:0];
        expect_no_bus("R2 page write no bus");
    endtask

    task automatic wr_win(input logic [3:0] w, input logic [15:0] v);
        logic [15:0] rd; bit got;
        md_access(PHY, {1'b0, w}, 1, v, rd, got);
        m_lo = v; m_win = w;
        expect_no_bus("R3 window write no bus");
    endtask

    task automatic wr_high(input logic [15:0] v, input string tag);
        logic [15:0] rd; bit got;
        md_access(PHY, 5'h10, 1, v, rd, got);
        expect_bus(tag, {m_page, m_win}, 1, {v, m_lo});
    endtask

    task automatic rd_expect(input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] exp, input string tag);
        logic [15:0] rd; bit got;
        md_access(phy, rg, 0, 16'h0, rd, got);
        chk(got, {tag, " strobe"}, 32'(got), 1);
        chk(rd == exp, tag, 32'(rd), 32'(exp));
    endtask

    task automatic rd_win(input logic [3:0] w, input string tag);
        logic [31:0] word;
        word = mem_rd({m_page, w});
        rd_expect(PHY, {1'b0, w}, word[15:0], tag);
        m_hi = word[31:16];
        expect_bus({tag, " bus"}, {m_page, w}, 0, word);
    endtask

    // window read followed by a high read held against the busy flag
    task automatic rd_pair(input logic [3:0] w, input int l);
        logic [31:0] word;
        int n;
        lat = l;
        word = mem_rd({m_page, w});
        @(negedge clk);
        md_phy = PHY; md_reg = {1'b0, w}; md_wr = 1'b0; md_req = 1'b1;
        while (md_busy) @(negedge clk);
        @(negedge clk);
        md_reg = 5'h10;
        n = 0;
        while (md_busy) begin n++; @(negedge clk); end
        chk(n == l + 1, "R7 stall length", 32'(n), 32'(l + 1));
        chk(md_rvalid && md_rdata == word[15:0], "R5 low after stall",
            32'(md_rdata), 32'(word[15:0]));
        @(negedge clk);
        md_req = 1'b0;
        chk(md_rvalid && md_rdata == word[31:16], "R6 high from same access",
            32'(md_rdata), 32'(word[31:16]));
        m_hi = word[31:16];
        expect_bus("R5 pair bus", {m_page, w}, 0, word);
        lat = 0;
    endtask

    initial begin
        logic [15:0] rd; bit got;
        repeat (3) @(negedge clk);
        chk(!md_busy && !bus_req && !md_rvalid, "R9 reset outputs",
            {29'd0, md_busy, bus_req, md_rvalid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        rd_expect(PHY, 5'h10, 16'h0000, "R9 R6 high after reset");
        rd_expect(PHY, 5'h1F, 16'h0000, "R9 R2 page after reset");
        wr_high(16'h1357, "R9 R4 high write after reset");

        wr_page(16'h02A5);
        rd_expect(PHY, 5'h1F, 16'h02A5, "R2 page readback");
        wr_page(16'hFFFF);
        rd_expect(PHY, 5'h1F, 16'h03FF, "R2 page upper bits dropped");
        wr_page(16'h0123);

        wr_win(4'h5, 16'h1234);
        wr_high(16'hABCD, "R4 committed write");
        rd_win(4'h5, "R5 window read written word");
        rd_expect(PHY, 5'h10, 16'hABCD, "R6 high half of written word");

        lat = 4;
        wr_win(4'hF, 16'h0F0F);
        wr_high(16'hF0F0, "R4 R8 write with latency");
        rd_win(4'hE, "R5 R8 read with latency");
        rd_expect(PHY, 5'h10, m_hi, "R6 high after latency read");
        lat = 0;

        // foreign PHY traffic touches nothing
        md_access(5'h01, 5'h1F, 1, 16'h0055, rd, got);
        expect_no_bus("R1 foreign page write no bus");
        rd_expect(PHY, 5'h1F, 16'h0123, "R1 page unchanged");
        md_access(5'h02, 5'h03, 1, 16'hFFFF, rd, got);
        expect_no_bus("R1 foreign window write no bus");
        md_access(5'h1E, 5'h10, 1, 16'h7777, rd, got);
        expect_no_bus("R1 foreign high write no bus");
        md_access(5'h00, 5'h10, 0, 16'h0, rd, got);
        chk(!got, "R1 foreign read no strobe", 32'(got), 0);
        md_access(5'h00, 5'h04, 0, 16'h0, rd, got);
        chk(!got, "R1 foreign window read no strobe", 32'(got), 0);
        expect_no_bus("R1 foreign read no bus");
        rd_expect(PHY, 5'h10, m_hi, "R1 held high unchanged");
        wr_high(16'h2222, "R1 low half and window unchanged");

        rd_expect(PHY, 5'h15, 16'h0000, "R10 unused register reads zero");
        rd_expect(PHY, 5'h11, 16'h0000, "R10 register 0x11 reads zero");
        expect_no_bus("R10 no bus");

        rd_pair(4'h3, 0);
        rd_pair(4'h9, 5);
        wr_page(16'h0000);
        rd_pair(4'h0, 2);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule